// File: doc/BRIEF.md
# Fractional PLL Rate Calculator

This block works out the output frequency of a fractional-N PLL from its settings. The settings are the parent (reference) frequency, the integer multiplier L, the fraction numerator M and denominator N, and a post-divider field. The rate is the parent times L, plus the parent times M divided by N with the remainder dropped. When N is zero the fraction term is left out. The sum is then divided by the post-divider field plus one, again with the remainder dropped.

The same request also looks up a frequency table held in a parameter array. Given a requested frequency, the block returns the first table entry that is at least as large. If no entry qualifies, it returns the computed rate instead. Software-style rate negotiation can use this answer as the frequency a PLL will actually run at.

All the arithmetic runs on one shift-add multiplier and one restoring shift-subtract divider. The divider is used twice, so each request takes a fixed number of cycles. A single `start` pulse launches a request and `valid` marks the answer.

Top module: `pll_rate_calc`

## Requirements
- R1: Only the low 10 bits of `l_in` and the low 19 bits of `m_in` and `n_in` are used. Higher bits have no effect on any result.
- R2: `rate_hz` equals parent × L + floor(parent × M / N), with the parent × M product kept at 64 bits before the division.
- R3: When the masked N is zero, the fraction term is omitted and the result is parent × L, divided as in R4.
- R4: With the post-divider enabled (PDIV_ON = 1), the sum from R2/R3 is divided by (`pdiv` + 1) and truncated. `pdiv` = 0 leaves it unchanged.
- R5: The lookup scans `FREQ_TBL` from index 0 upward. It returns in `pick_hz` the first entry whose value is greater than or equal to `req_hz`, with `hit` = 1.
- R6: An entry of value 0 ends the scan, so entries at higher indices are never chosen.
- R7: If the scan finds no entry, `pick_hz` equals the computed `rate_hz` and `hit` = 0.
- R8: After a `start` accepted while idle, `busy` is high and `valid` pulses for exactly one cycle, 148 (MN_W + 2·RATE_W + 1) rising edges after the accepting edge. At that point `busy` is low and all results are updated.
- R9: A `start` seen while `busy` is high is ignored. It changes neither the timing nor the results of the request in flight.
- R10: After reset, `busy`, `valid` and `hit` are 0, and `rate_hz` and `pick_hz` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only while idle |
| parent_hz | input | PAR_W (32) | Parent frequency in Hz |
| l_in | input | IN_W (32) | Integer multiplier, low 10 bits used |
| m_in | input | IN_W (32) | Fraction numerator, low 19 bits used |
| n_in | input | IN_W (32) | Fraction denominator, low 19 bits used |
| pdiv | input | PDIV_W (3) | Post-divider field, divide by value + 1 |
| req_hz | input | RATE_W (64) | Requested frequency for the table lookup |
| busy | output | 1 | Calculation in progress |
| valid | output | 1 | One-cycle pulse when results are updated |
| hit | output | 1 | Table entry selected by the lookup |
| rate_hz | output | RATE_W (64) | Computed output frequency |
| pick_hz | output | RATE_W (64) | Lookup result: table entry or computed rate |

## Verification
Every result is due a fixed 148 edges after the edge that accepts `start`. That is 19 multiplier steps, two 64-step divisions and one lookup cycle. The bench's model counts down the same window from that accepting edge. It compares `busy` and `valid` on every cycle, and it compares the rate, pick and hit values on every cycle in which the model is idle. This keeps the mid-calculation update of `rate_hz` out of the comparison. A strobe given in the middle of a request must leave both the countdown and the values unchanged.

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int PAR_W   = 32,
  parameter int IN_W    = 32,
  parameter int L_W     = 10,
  parameter int MN_W    = 19,
  parameter int RATE_W  = 64,
  parameter int PDIV_W  = 3,
  parameter bit PDIV_ON = 1'b1,
  parameter int TBL_N   = 4,
  parameter logic [TBL_N-1:0][RATE_W-1:0] FREQ_TBL =
    {64'd0, 64'd1_200_000_000, 64'd800_000_000, 64'd384_000_000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAR_W-1:0]  parent_hz,
  input  logic [IN_W-1:0]   l_in,
  input  logic [IN_W-1:0]   m_in,
  input  logic [IN_W-1:0]   n_in,
  input  logic [PDIV_W-1:0] pdiv,
  input  logic [RATE_W-1:0] req_hz,
  output logic              busy,
  output logic              valid,
  output logic              hit,
  output logic [RATE_W-1:0] rate_hz,
  output logic [RATE_W-1:0] pick_hz
);

  localparam int CNT_W = $clog2(RATE_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_DIV1, S_DIV2, S_FIN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [RATE_W-1:0] mcand, q, acc_l, rem, dvs, req_q;
  logic [MN_W-1:0]   mbits, lbits, nreg;
  logic [PDIV_W-1:0] pdq;
  logic [RATE_W-1:0] pdiv_dvs;

  logic              unused_hi;
  assign unused_hi = ^{l_in[IN_W-1:L_W], m_in[IN_W-1:MN_W], n_in[IN_W-1:MN_W]};

  generate
    if (PDIV_ON) begin : g_pdiv
      assign pdiv_dvs = RATE_W'(pdq) + RATE_W'(1);
    end else begin : g_nopdiv
      logic unused_pd;
      assign unused_pd = ^pdq;
      assign pdiv_dvs  = RATE_W'(1);
    end
  endgenerate

  logic [RATE_W:0]   rem_sh, sub;
  logic              ge;
  logic [RATE_W-1:0] rem_nx, q_nx;
  assign rem_sh = {rem, q[RATE_W-1]};
  assign sub    = rem_sh - {1'b0, dvs};
  assign ge     = ~sub[RATE_W];
  assign rem_nx = ge ? sub[RATE_W-1:0] : rem_sh[RATE_W-1:0];
  assign q_nx   = {q[RATE_W-2:0], ge};

  logic              hit_c, stop_c;
  logic [RATE_W-1:0] pick_c;
  always_comb begin
    hit_c  = 1'b0;
    stop_c = 1'b0;
    pick_c = rate_hz;
    for (int i = 0; i < TBL_N; i++) begin
      if (!stop_c) begin
        if (FREQ_TBL[i] == '0) begin
          stop_c = 1'b1;
        end else if (req_q <= FREQ_TBL[i]) begin
          stop_c = 1'b1;
          hit_c  = 1'b1;
          pick_c = FREQ_TBL[i];
        end
      end
    end
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      mcand   <= '0;
      q       <= '0;
      acc_l   <= '0;
      rem     <= '0;
      dvs     <= '0;
      req_q   <= '0;
      mbits   <= '0;
      lbits   <= '0;
      nreg    <= '0;
      pdq     <= '0;
      valid   <= 1'b0;
      hit     <= 1'b0;
      rate_hz <= '0;
      pick_hz <= '0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_MUL;
          cnt   <= '0;
          mcand <= RATE_W'(parent_hz);
          q     <= '0;
          acc_l <= '0;
          mbits <= m_in[MN_W-1:0];
          lbits <= MN_W'(l_in[L_W-1:0]);
          nreg  <= n_in[MN_W-1:0];
          pdq   <= pdiv;
          req_q <= req_hz;
        end
        S_MUL: begin
          if (mbits[0]) q     <= q + mcand;
          if (lbits[0]) acc_l <= acc_l + mcand;
          mcand <= mcand << 1;
          mbits <= mbits >> 1;
          lbits <= lbits >> 1;
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(MN_W - 1)) begin
            st  <= S_DIV1;
            cnt <= '0;
            rem <= '0;
            dvs <= RATE_W'(nreg);
          end
        end
        S_DIV1: begin
          rem <= rem_nx;
          q   <= q_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(RATE_W - 1)) begin
            st  <= S_DIV2;
            cnt <= '0;
            rem <= '0;
            dvs <= pdiv_dvs;
            q   <= acc_l + ((nreg == '0) ? '0 : q_nx);
          end
        end
        S_DIV2: begin
          rem <= rem_nx;
          q   <= q_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(RATE_W - 1)) begin
            st      <= S_FIN;
            rate_hz <= q_nx;
          end
        end
        S_FIN: begin
          st      <= S_IDLE;
          valid   <= 1'b1;
          hit     <= hit_c;
          pick_hz <= pick_c;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
  parameter int RATE_W = 64,
  parameter int LAT    = 148
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              valid,
  input logic              hit,
  input logic [RATE_W-1:0] rate_hz,
  input logic [RATE_W-1:0] pick_hz
);

  logic [15:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> bcnt == 16'(LAT));
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || valid));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rate_hz));
  p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !hit) |-> pick_hz == rate_hz);
  p_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && hit) |-> pick_hz != '0);

endmodule

bind pll_rate_calc pll_rate_calc_chk #(
  .RATE_W(RATE_W),
  .LAT(MN_W + 2 * RATE_W + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .valid(valid),
  .hit(hit), .rate_hz(rate_hz), .pick_hz(pick_hz)
);

// File: tb/pll_rate_calc_tb.sv
module pll_rate_calc_tb;
  localparam int CLK_P = 10;
  localparam int LAT   = 148;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parent_hz = '0, l_in = '0, m_in = '0, n_in = '0;
  logic [2:0]  pdiv = '0;
  logic [63:0] req_hz = '0;
  logic        busy, valid, hit;
  logic [63:0] rate_hz, pick_hz;

  longint unsigned tbl [4] = '{64'd384_000_000, 64'd800_000_000, 64'd0, 64'd2_000_000_000};

  pll_rate_calc #(
    .FREQ_TBL({64'd2_000_000_000, 64'd0, 64'd800_000_000, 64'd384_000_000})
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .parent_hz(parent_hz),
    .l_in(l_in), .m_in(m_in), .n_in(n_in), .pdiv(pdiv), .req_hz(req_hz),
    .busy(busy), .valid(valid), .hit(hit), .rate_hz(rate_hz), .pick_hz(pick_hz)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  string rtag = "R10", ltag = "R10";

  logic busy_m, valid_m, hit_m, p_hit;
  longint unsigned rate_m, pick_m, p_rate, p_pick;
  int left;

  function automatic longint unsigned calc(longint unsigned p, longint unsigned l,
                                           longint unsigned m, longint unsigned n,
                                           longint unsigned d);
    longint unsigned r;
    l = l & 64'h3ff; m = m & 64'h7ffff; n = n & 64'h7ffff;
    r = p * l;
    if (n != 0) r = r + (p * m) / n;
    return r / (d + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 0; valid_m <= 0; hit_m <= 0; rate_m <= 0; pick_m <= 0; left <= 0;
    end else begin
      valid_m <= 0;
      if (!busy_m) begin
        if (start) begin
          longint unsigned r;
          bit h;
          longint unsigned pk;
          r = calc(parent_hz, l_in, m_in, n_in, pdiv);
          h = 0; pk = r;
          for (int i = 0; i < 4; i++) begin
            if (tbl[i] == 0) break;
            if (req_hz <= tbl[i]) begin h = 1; pk = tbl[i]; break; end
          end
          p_rate <= r; p_pick <= pk; p_hit <= h;
          busy_m <= 1; left <= LAT;
        end
      end else begin
        if (left == 1) begin
          busy_m <= 0; valid_m <= 1;
          rate_m <= p_rate; pick_m <= p_pick; hit_m <= p_hit;
        end
        left <= left - 1;
      end
    end
  end

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8", "busy", busy, busy_m);
      chk("R8", "valid", valid, valid_m);
      if (!busy_m) begin
        chk(rtag, "rate", rate_hz, rate_m);
        chk(ltag, "pick", pick_hz, pick_m);
        chk(ltag, "hit", hit, hit_m);
      end
    end
  end

  task automatic run(string rt, string lt, logic [31:0] p, logic [31:0] l,
                     logic [31:0] m, logic [31:0] n, logic [2:0] d, logic [63:0] rq);
    @(negedge clk);
    rtag = rt; ltag = lt;
    parent_hz = p; l_in = l; m_in = m; n_in = n; pdiv = d; req_hz = rq; start = 1;
    @(negedge clk);
    start = 0;
    repeat (LAT + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset rate", rate_hz, 0);
    chk("R10", "reset pick", pick_hz, 0);
    run("R2", "R5", 32'd19_200_000, 32'd41, 32'd2, 32'd3, 3'd0, 64'd500_000_000);
    run("R1", "R5", 32'd19_200_000, 32'h0000_FC29, 32'hFFF8_0002, 32'h0008_0003, 3'd0, 64'd384_000_000);
    run("R3", "R5", 32'd24_000_000, 32'd20, 32'd5, 32'd0, 3'd0, 64'd100_000_000);
    run("R4", "R7", 32'd27_000_001, 32'd7, 32'd1, 32'd3, 3'd4, 64'd900_000_000);
    run("R4", "R5", 32'd19_200_000, 32'd62, 32'd1, 32'd2, 3'd1, 64'd384_000_001);
    run("R2", "R6", 32'd19_200_000, 32'd80, 32'd0, 32'd1, 3'd0, 64'd1_000_000_000);
    run("R2", "R7", 32'hFFFF_FFFF, 32'h3FF, 32'h7FFFF, 32'd1, 3'd7, 64'hFFFF_FFFF_FFFF);
    // R9: second strobe mid-flight with other operands
    @(negedge clk);
    rtag = "R9"; ltag = "R9";
    parent_hz = 32'd10_000_000; l_in = 32'd30; m_in = 32'd1; n_in = 32'd4; pdiv = 0;
    req_hz = 64'd200_000_000; start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    parent_hz = 32'd50_000_000; l_in = 32'd3; req_hz = 64'd900_000_000; start = 1;
    @(negedge clk); start = 0;
    repeat (LAT) @(negedge clk);
    for (int k = 0; k < 6; k++)
      run("R2", "R5", $urandom, $urandom, $urandom, $urandom, 3'($urandom),
          {32'd0, $urandom});
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule